// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings single-data-rate SDRAM devices from power-up to a usable state. Once reset is released, it holds the devices idle with clock enable high for a programmable number of clocks. It then closes every bank, refreshes the array eight times and writes the mode register. Each command is followed by the wait the device requires before the next command. When the last wait has elapsed, the block raises a completion flag. Until that flag is up, the data mask stays asserted so that no stray write can land in the array.

The startup delay, the precharge, refresh and mode-register waits, the CAS latency and the encoded burst length are all runtime inputs. They are meant to be tied off or held stable while a sequence runs. A one-cycle init strobe restarts the whole sequence from the idle delay at any time, including partway through a sequence. The mode word is built from the CAS latency and burst code inputs, with the burst type fixed to sequential. The command, address and chip-select pins are registered, so a command reaches the pins one clock after the sequencer decides to issue it.

Top module: `sdram_init_seq`

## Requirements
- R1: While rstN is low, memCke is 0, memCsN is all ones, memRasN, memCasN and memWeN are 1, memDqm is 1 and initDone is 0.
- R2: After the trigger (release of reset, or the clock edge that samples initStrobe high), the first startDelay pin cycles carry NOP with memCke at 1, and the following cycle carries precharge-all.
- R3: Precharge-all drives memRasN=0, memCasN=1, memWeN=0, memAddr=0x0400 (bit 10 set, all other bits 0), memBa=0 and all memCsN bits low.
- R4: The first auto-refresh appears exactly tRp cycles after precharge-all.
- R5: Exactly eight auto-refresh commands are issued (memRasN=0, memCasN=0, memWeN=1, all chip selects low, address 0). Successive refreshes are tRfc cycles apart, and the load-mode command comes tRfc cycles after the eighth refresh.
- R6: Load-mode drives memRasN, memCasN and memWeN all to 0 with all chip selects low. memAddr[2:0] is {0, burstEnc}, memAddr[3] is 0 (sequential), memAddr[6:4] is casLat and memAddr[13:7] is 0.
- R7: initDone rises exactly tMrd cycles after the load-mode command and then stays high. From then on, the pins carry only NOP with chip selects high.
- R8: memDqm equals 1 whenever initDone is 0, and 0 whenever initDone is 1.
- R9: An initStrobe pulse, whether partway through a sequence or after completion, clears initDone and replays the full sequence starting with the startDelay NOP phase.
- R10: Every command lasts one cycle. Every other cycle of the sequence is a NOP with memCsN all ones, memAddr 0 and memBa 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initStrobe | input | 1 | One-cycle restart of the sequence |
| startDelay | input | 16 | NOP clocks before precharge-all |
| tRp | input | 3 | Clocks from precharge-all to first refresh |
| tRfc | input | 4 | Clocks from each refresh to the next command |
| tMrd | input | 3 | Clocks from load-mode to completion |
| casLat | input | 3 | CAS latency written to the mode word |
| burstEnc | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8) |
| memCke | output | 1 | SDRAM clock enable |
| memCsN | output | 8 | Chip selects, active low |
| memRasN | output | 1 | Row strobe command pin |
| memCasN | output | 1 | Column strobe command pin |
| memWeN | output | 1 | Write enable command pin |
| memAddr | output | 14 | Address bus (precharge-all flag, mode word) |
| memBa | output | 2 | Bank address |
| memDqm | output | 1 | Data mask |
| initDone | output | 1 | Sequence complete |

## Verification
A corrupted wait counter appears at the pins as a command landing one or more cycles early or late. The bench catches it on the very next command, because it compares every pin on every cycle against an arithmetic schedule. A wrong refresh index appears as a seventh or ninth refresh, or as a load-mode command issued too early, and this shows within one tRfc window. A sequencer that ignores or mishandles a restart shows a stale completion flag, or a missing NOP phase, within startDelay+1 cycles of the strobe.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2,
    CMD_LMR = 2'd3
  } memCmd_e;

  typedef struct packed {
    logic    ckeOn;
    memCmd_e cmd;
    logic    seqDone;
  } seqStrobe_t;

  // {ras_n, cas_n, we_n} for each command
  function automatic logic [2:0] cmdPins(input memCmd_e c);
    case (c)
      CMD_PRE: cmdPins = 3'b010;
      CMD_REF: cmdPins = 3'b001;
      CMD_LMR: cmdPins = 3'b000;
      default: cmdPins = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int DELAY_W     = 16,
  parameter int RP_W        = 3,
  parameter int RFC_W       = 4,
  parameter int MRD_W       = 3,
  parameter int NUM_REFRESH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               initStrobe,
  input  logic [DELAY_W-1:0] startDelay,
  input  logic [RP_W-1:0]    tRp,
  input  logic [RFC_W-1:0]   tRfc,
  input  logic [MRD_W-1:0]   tMrd,
  output seqStrobe_t         strobe
);

  localparam int W_A   = (DELAY_W > RP_W) ? DELAY_W : RP_W;
  localparam int W_B   = (RFC_W > MRD_W) ? RFC_W : MRD_W;
  localparam int CNT_W = (W_A > W_B) ? W_A : W_B;
  localparam int REF_W = (NUM_REFRESH > 1) ? $clog2(NUM_REFRESH) : 1;
  localparam logic [REF_W-1:0] LAST_REF = REF_W'(NUM_REFRESH - 1);

  typedef enum logic [2:0] {
    ST_NOP,
    ST_PRE,
    ST_REF,
    ST_LMR,
    ST_DONE
  } seqState_e;

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] refIdx;
  logic [CNT_W-1:0] target;
  logic [CNT_W:0]   cntInc;
  logic             lastCycle;

  // Length of the phase the sequencer is in; the issue cycle counts as its first clock.
  always_comb begin
    case (state)
      ST_NOP:  target = CNT_W'(startDelay);
      ST_PRE:  target = CNT_W'(tRp);
      ST_REF:  target = CNT_W'(tRfc);
      ST_LMR:  target = CNT_W'(tMrd);
      default: target = '0;
    endcase
  end

  assign cntInc    = {1'b0, cnt} + (CNT_W + 1)'(1);
  assign lastCycle = (cntInc >= {1'b0, target});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_NOP;
      cnt    <= '0;
      refIdx <= '0;
    end else if (initStrobe) begin
      state  <= ST_NOP;
      cnt    <= '0;
      refIdx <= '0;
    end else begin
      case (state)
        ST_NOP: begin
          if (lastCycle) begin
            state <= ST_PRE;
            cnt   <= '0;
          end else begin
            cnt <= cntInc[CNT_W-1:0];
          end
        end
        ST_PRE: begin
          if (lastCycle) begin
            state <= ST_REF;
            cnt   <= '0;
          end else begin
            cnt <= cntInc[CNT_W-1:0];
          end
        end
        ST_REF: begin
          if (lastCycle) begin
            cnt <= '0;
            if (refIdx == LAST_REF) begin
              state  <= ST_LMR;
              refIdx <= '0;
            end else begin
              refIdx <= refIdx + REF_W'(1);
            end
          end else begin
            cnt <= cntInc[CNT_W-1:0];
          end
        end
        ST_LMR: begin
          if (lastCycle) begin
            state <= ST_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cntInc[CNT_W-1:0];
          end
        end
        default: begin
          state <= ST_DONE;
        end
      endcase
    end
  end

  // Strobes to the datapath: a command only on the first clock of its phase.
  always_comb begin
    strobe.ckeOn   = 1'b1;
    strobe.seqDone = (state == ST_DONE);
    strobe.cmd     = CMD_NOP;
    if (cnt == '0) begin
      case (state)
        ST_PRE:  strobe.cmd = CMD_PRE;
        ST_REF:  strobe.cmd = CMD_REF;
        ST_LMR:  strobe.cmd = CMD_LMR;
        default: strobe.cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_init_datapath.sv
module sdram_init_datapath
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int BA_W     = 2,
  parameter int CS_W     = 8,
  parameter int CL_W     = 3,
  parameter int BL_W     = 2,
  parameter int PALL_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [CL_W-1:0]   casLat,
  input  logic [BL_W-1:0]   burstEnc,
  output logic              memCke,
  output logic [CS_W-1:0]   memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BA_W-1:0]   memBa,
  output logic              memDqm,
  output logic              initDone
);

  localparam int BL_FIELD_W = 3;
  localparam int BT_BIT     = 3;
  localparam int CL_LSB     = 4;
  localparam logic [ADDR_W-1:0] PALL_WORD = ADDR_W'(1) << PALL_BIT;

  logic [ADDR_W-1:0] modeWord;
  logic [ADDR_W-1:0] addrNext;
  logic [CS_W-1:0]   csNext;

  // Mode word: burst code, sequential burst type, CAS latency, upper bits zero.
  always_comb begin
    modeWord = '0;
    modeWord[BL_FIELD_W-1:0]     = BL_FIELD_W'(burstEnc);
    modeWord[BT_BIT]             = 1'b0;
    modeWord[CL_LSB +: CL_W]     = casLat;
  end

  always_comb begin
    case (strobe.cmd)
      CMD_PRE: addrNext = PALL_WORD;
      CMD_LMR: addrNext = modeWord;
      default: addrNext = '0;
    endcase
    csNext = (strobe.cmd == CMD_NOP) ? '1 : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCke   <= 1'b0;
      memCsN   <= '1;
      memRasN  <= 1'b1;
      memCasN  <= 1'b1;
      memWeN   <= 1'b1;
      memAddr  <= '0;
      memBa    <= '0;
      memDqm   <= 1'b1;
      initDone <= 1'b0;
    end else begin
      memCke                      <= strobe.ckeOn;
      memCsN                      <= csNext;
      {memRasN, memCasN, memWeN}  <= cmdPins(strobe.cmd);
      memAddr                     <= addrNext;
      memBa                       <= '0;
      memDqm                      <= ~strobe.seqDone;
      initDone                    <= strobe.seqDone;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int DELAY_W     = 16,
  parameter int RP_W        = 3,
  parameter int RFC_W       = 4,
  parameter int MRD_W       = 3,
  parameter int CL_W        = 3,
  parameter int BL_W        = 2,
  parameter int ADDR_W      = 14,
  parameter int BA_W        = 2,
  parameter int CS_W        = 8,
  parameter int NUM_REFRESH = 8,
  parameter int PALL_BIT    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initStrobe,
  input  logic [DELAY_W-1:0] startDelay,
  input  logic [RP_W-1:0]   tRp,
  input  logic [RFC_W-1:0]  tRfc,
  input  logic [MRD_W-1:0]  tMrd,
  input  logic [CL_W-1:0]   casLat,
  input  logic [BL_W-1:0]   burstEnc,
  output logic              memCke,
  output logic [CS_W-1:0]   memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BA_W-1:0]   memBa,
  output logic              memDqm,
  output logic              initDone
);

  seqStrobe_t strobe;

  sdram_init_ctrl #(
    .DELAY_W    (DELAY_W),
    .RP_W       (RP_W),
    .RFC_W      (RFC_W),
    .MRD_W      (MRD_W),
    .NUM_REFRESH(NUM_REFRESH)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .initStrobe(initStrobe),
    .startDelay(startDelay),
    .tRp       (tRp),
    .tRfc      (tRfc),
    .tMrd      (tMrd),
    .strobe    (strobe)
  );

  sdram_init_datapath #(
    .ADDR_W  (ADDR_W),
    .BA_W    (BA_W),
    .CS_W    (CS_W),
    .CL_W    (CL_W),
    .BL_W    (BL_W),
    .PALL_BIT(PALL_BIT)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .casLat  (casLat),
    .burstEnc(burstEnc),
    .memCke  (memCke),
    .memCsN  (memCsN),
    .memRasN (memRasN),
    .memCasN (memCasN),
    .memWeN  (memWeN),
    .memAddr (memAddr),
    .memBa   (memBa),
    .memDqm  (memDqm),
    .initDone(initDone)
  );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int RP_W   = 3,
  parameter int RFC_W  = 4,
  parameter int MRD_W  = 3,
  parameter int CL_W   = 3,
  parameter int BL_W   = 2,
  parameter int ADDR_W = 14,
  parameter int BA_W   = 2,
  parameter int CS_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [RP_W-1:0]   tRp,
  input logic [RFC_W-1:0]  tRfc,
  input logic [MRD_W-1:0]  tMrd,
  input logic [CL_W-1:0]   casLat,
  input logic [BL_W-1:0]   burstEnc,
  input logic              memCke,
  input logic [CS_W-1:0]   memCsN,
  input logic              memRasN,
  input logic              memCasN,
  input logic              memWeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [BA_W-1:0]   memBa,
  input logic              memDqm,
  input logic              initDone
);

  localparam int GW = 8;
  localparam logic [GW-1:0] GMAX = '1;

  logic isPre, isRef, isLmr;
  logic [GW-1:0] sincePre, sinceRef, sinceLmr;
  logic refSeen;

  assign isPre = (memCsN == '0) && !memRasN &&  memCasN && !memWeN;
  assign isRef = (memCsN == '0) && !memRasN && !memCasN &&  memWeN;
  assign isLmr = (memCsN == '0) && !memRasN && !memCasN && !memWeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sincePre <= GMAX;
      sinceRef <= GMAX;
      sinceLmr <= GMAX;
      refSeen  <= 1'b0;
    end else begin
      sincePre <= isPre ? GW'(1) : ((sincePre == GMAX) ? GMAX : sincePre + GW'(1));
      sinceRef <= isRef ? GW'(1) : ((sinceRef == GMAX) ? GMAX : sinceRef + GW'(1));
      sinceLmr <= isLmr ? GW'(1) : ((sinceLmr == GMAX) ? GMAX : sinceLmr + GW'(1));
      if (isPre)      refSeen <= 1'b0;
      else if (isRef) refSeen <= 1'b1;
    end
  end

  a_r2_cke_stays: assert property (@(posedge clk) disable iff (!rstN)
    memCke |=> memCke);

  a_r3_pre_all_word: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> (memAddr == (ADDR_W'(1) << 10)) && (memBa == '0));

  a_r4_first_ref_gap: assert property (@(posedge clk) disable iff (!rstN)
    (isRef && !refSeen) |-> (sincePre == GW'(tRp)));

  a_r5_ref_gap: assert property (@(posedge clk) disable iff (!rstN)
    (isRef && refSeen) |-> (sinceRef == GW'(tRfc)));

  a_r5_lmr_gap: assert property (@(posedge clk) disable iff (!rstN)
    isLmr |-> (refSeen && (sinceRef == GW'(tRfc))));

  a_r6_mode_word: assert property (@(posedge clk) disable iff (!rstN)
    isLmr |-> (memAddr[6:4] == casLat[2:0]) && (memAddr[2:0] == 3'(burstEnc))
              && !memAddr[3] && (memAddr[ADDR_W-1:7] == '0));

  a_r7_done_timing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> (sinceLmr == GW'(tMrd)));

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (memCsN == '1));

  a_r8_dqm_track: assert property (@(posedge clk) disable iff (!rstN)
    memDqm == !initDone);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .RP_W  (RP_W),
  .RFC_W (RFC_W),
  .MRD_W (MRD_W),
  .CL_W  (CL_W),
  .BL_W  (BL_W),
  .ADDR_W(ADDR_W),
  .BA_W  (BA_W),
  .CS_W  (CS_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .tRp     (tRp),
  .tRfc    (tRfc),
  .tMrd    (tMrd),
  .casLat  (casLat),
  .burstEnc(burstEnc),
  .memCke  (memCke),
  .memCsN  (memCsN),
  .memRasN (memRasN),
  .memCasN (memCasN),
  .memWeN  (memWeN),
  .memAddr (memAddr),
  .memBa   (memBa),
  .memDqm  (memDqm),
  .initDone(initDone)
);

// File: tb/sdram_init_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initStrobe = 1'b0;
  logic [15:0] startDelay = 16'd10;
  logic [2:0]  tRp = 3'd2;
  logic [3:0]  tRfc = 4'd3;
  logic [2:0]  tMrd = 3'd2;
  logic [2:0]  casLat = 3'd2;
  logic [1:0]  burstEnc = 2'd3;

  logic        memCke;
  logic [7:0]  memCsN;
  logic        memRasN, memCasN, memWeN;
  logic [13:0] memAddr;
  logic [1:0]  memBa;
  logic        memDqm;
  logic        initDone;

  int tests = 0;
  int fails = 0;
  bit summaryDone = 1'b0;

  always #4 clk = ~clk;

  sdram_init_seq dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .initStrobe(initStrobe),
    .startDelay(startDelay),
    .tRp       (tRp),
    .tRfc      (tRfc),
    .tMrd      (tMrd),
    .casLat    (casLat),
    .burstEnc  (burstEnc),
    .memCke    (memCke),
    .memCsN    (memCsN),
    .memRasN   (memRasN),
    .memCasN   (memCasN),
    .memWeN    (memWeN),
    .memAddr   (memAddr),
    .memBa     (memBa),
    .memDqm    (memDqm),
    .initDone  (initDone)
  );

  function automatic logic [29:0] pinVec();
    return {memCke, memCsN, memRasN, memCasN, memWeN, memAddr, memBa, memDqm, initDone};
  endfunction

  function automatic logic [29:0] nopVec(input logic done);
    return {1'b1, 8'hFF, 3'b111, 14'h0, 2'b00, ~done, done};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  endtask

  // Compare every pin on every cycle against the schedule computed from the config.
  task automatic observe(input string ctx);
    int d, p, l, dn, last;
    d  = int'(startDelay);
    p  = d + 1;
    l  = p + int'(tRp) + 8 * int'(tRfc);
    dn = l + int'(tMrd);
    last = dn + 5;
    for (int i = 1; i <= last; i++) begin
      logic [29:0] exp;
      logic        doneExp;
      string       tag;
      @(negedge clk);
      doneExp = (i >= dn);
      exp = nopVec(doneExp);
      tag = "R10";
      if (i < p) tag = "R2";
      else if (i == p) begin
        exp = {1'b1, 8'h00, 3'b010, 14'h0400, 2'b00, 1'b1, 1'b0};
        tag = "R3";
      end else if (i == l) begin
        exp = {1'b1, 8'h00, 3'b000, 7'h0, casLat, 1'b0, 1'b0, burstEnc, 2'b00, 1'b1, 1'b0};
        tag = "R6";
      end else if (i >= p + int'(tRp) && i < l &&
                   ((i - p - int'(tRp)) % int'(tRfc)) == 0) begin
        exp = {1'b1, 8'h00, 3'b001, 14'h0, 2'b00, 1'b1, 1'b0};
        tag = (i == p + int'(tRp)) ? "R4" : "R5";
      end else if (doneExp) tag = "R7";
      check(pinVec() == exp, {tag, " ", ctx}, 32'(pinVec()), 32'(exp));
      check(memDqm == ~doneExp, {"R8 ", ctx}, 32'(memDqm), 32'(~doneExp));
    end
  endtask

  task automatic pulseStrobe();
    @(negedge clk);
    initStrobe = 1'b1;
    @(negedge clk);
    initStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finishRun();
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    check(pinVec() == {1'b0, 8'hFF, 3'b111, 14'h0, 2'b00, 1'b1, 1'b0}, "R1 reset pins",
          32'(pinVec()), 32'({1'b0, 8'hFF, 3'b111, 14'h0, 2'b00, 1'b1, 1'b0}));
    check(memCke == 1'b0, "R1 cke low", 32'(memCke), 32'd0);

    // Sequence after reset release
    rstN = 1'b1;
    observe("after reset");

    // Sweep the configuration with strobe-triggered runs
    begin
      int k;
      k = 0;
      for (int rp = 1; rp <= 4; rp++) begin
        for (int rf = 0; rf < 3; rf++) begin
          for (int mr = 0; mr < 3; mr++) begin
            tRp        = 3'(rp);
            tRfc       = (rf == 0) ? 4'd2 : ((rf == 1) ? 4'd5 : 4'd14);
            tMrd       = (mr == 0) ? 3'd1 : ((mr == 1) ? 3'd4 : 3'd7);
            casLat     = 3'(1 + (k % 4));
            burstEnc   = 2'(k % 4);
            startDelay = 16'(10 + (k % 3));
            k++;
            pulseStrobe();
            observe("R9 strobe sweep");
          end
        end
      end
    end

    // R9: restart partway through the sequence at several points
    tRp = 3'd3; tRfc = 4'd4; tMrd = 3'd3; casLat = 3'd3; burstEnc = 2'd2; startDelay = 16'd12;
    for (int w = 0; w < 4; w++) begin
      pulseStrobe();
      repeat ((w == 0) ? 5 : ((w == 1) ? 14 : ((w == 2) ? 30 : 48))) @(negedge clk);
      pulseStrobe();
      observe("R9 mid-sequence restart");
    end

    // R9: back-to-back strobes keep restarting
    @(negedge clk);
    initStrobe = 1'b1;
    repeat (3) @(negedge clk);
    initStrobe = 1'b0;
    observe("R9 held strobe");

    finishRun();
  end

endmodule